// File: doc/BRIEF.md
# Data Space Access Router

This block sits between an 8051-class CPU core and the storage and register targets behind it. Each cycle the core presents one data-memory request: an address, an access kind, a read/write flag and write data. The router works out which target owns that request, forwards it, and returns read data and a ready flag to the core. In the internal 256-byte space, the upper half is split by addressing mode. Direct accesses reach the special function registers. Indirect and stack accesses reach internal RAM.

The external (16-bit) space holds several windows. There is external RAM, a block of extra controller registers, and an alias of the special function registers. There is also a slow radio register bank, reachable through two aliases. The blocking alias holds the core until the radio answers. The non-blocking alias starts the radio transaction and releases the core at once. A status byte reports whether the radio engine is busy. A holding byte keeps the data returned by the last non-blocking read.

Four fast targets share one request bus with a one-hot select. The radio bank has its own request port, so its transaction can keep running while the core moves on.

Top module: `dsr_router`

## Requirements
- R1: An internal access (kind 0 direct, 1 indirect, 3 stack) with address bit 7 clear selects internal RAM (tgt_req bit 0), with target address {8'h00, addr[7:0]}.
- R2: A direct internal access (kind 0) with address bit 7 set selects the special function registers (tgt_req bit 1), with target address {8'h00, addr[7:0]}.
- R3: An indirect or stack internal access (kind 1 or 3) with address bit 7 set selects internal RAM (tgt_req bit 0).
- R4: External accesses (kind 2) map as follows:
  - 0x0000–0x1FFF selects external RAM (bit 2, full address).
  - 0x3000–0x3EFF selects controller registers (bit 3, full address).
  - 0x3F80–0x3FFF selects the special function registers (bit 1, address {8'h00, addr[7:0]}).
  - A fast access completes in the cycle its tgt_ack is high and returns that target's data.
- R5: External 0x4000–0x4FFF is the blocking radio alias. The radio offset addr[11:0] is launched on the next edge. cpu_ready stays low until the cycle rad_ack is high, and cpu_rdata then equals rad_rdata.
- R6: External 0x5000–0x5FFF is the non-blocking radio alias. With the engine idle, cpu_ready is high in the same cycle. From the next cycle, rad_req stays high, with stable rad_addr, rad_we and rad_wdata, until rad_ack.
- R7: A radio access through either alias while the engine is busy holds cpu_ready low. It is launched on the first edge after the pending transaction's rad_ack.
- R8: An external read of 0x3F00 completes at once and returns the engine busy flag in bit 0, with all other bits 0.
- R9: When a non-blocking read completes, rad_rdata is latched at that rad_ack edge. An external read of 0x3F01 completes at once and returns the latched byte. A read in the rad_ack cycle itself still returns the previous byte.
- R10: Any other external address completes in the same cycle and returns 0x00. It raises no tgt_req and no rad_req, so writes there have no effect.
- R11: After reset, no target request is raised, the radio engine is idle and the holding byte reads 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Core request valid |
| cpu_kind | input | 2 | Access kind: 0 direct, 1 indirect, 2 external, 3 stack |
| cpu_addr | input | 16 | Request address |
| cpu_we | input | 1 | 1 = write |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Read data, valid when cpu_ready |
| cpu_ready | output | 1 | Request completes this cycle |
| tgt_req | output | 4 | One-hot fast target select: IRAM, SFR, XRAM, controller regs |
| tgt_addr | output | 16 | Fast target address |
| tgt_we | output | 1 | Fast target write |
| tgt_wdata | output | 8 | Fast target write data |
| tgt_rdata | input | 32 | Fast target read data, 8 bits per target, target 0 lowest |
| tgt_ack | input | 4 | Fast target acknowledge |
| rad_req | output | 1 | Radio transaction pending |
| rad_addr | output | 12 | Radio register offset |
| rad_we | output | 1 | Radio write |
| rad_wdata | output | 8 | Radio write data |
| rad_rdata | input | 8 | Radio read data, valid with rad_ack |
| rad_ack | input | 1 | Radio transaction done |

## Verification
The completion of a non-blocking radio transaction can fall in the same cycle as a new core request. That request may read the status byte, read the holding byte, start another radio access, or use a fast target. The bench provokes this by issuing a non-blocking read or write and then, with no idle gap, a chain of such requests that spans the acknowledge cycle. A behavioural model then judges every cycle. It expects a status read in the acknowledge cycle to still return busy. It expects a holding read in that cycle to return the old byte. It expects a queued radio access to launch only on the following edge, and a fast access to complete untouched.

// File: rtl/dsr_pkg.sv
package dsr_pkg;

  localparam int NUM_SHARED = 4;

  typedef enum logic [1:0] {
    KIND_DIR = 2'd0,
    KIND_IND = 2'd1,
    KIND_EXT = 2'd2,
    KIND_STK = 2'd3
  } acc_kind_e;

  // Values 0..3 double as the fast-target index on the shared bus
  typedef enum logic [3:0] {
    RG_IRAM = 4'd0,
    RG_SFR  = 4'd1,
    RG_XRAM = 4'd2,
    RG_CREG = 4'd3,
    RG_RBLK = 4'd4,
    RG_RNB  = 4'd5,
    RG_STAT = 4'd6,
    RG_HOLD = 4'd7,
    RG_NONE = 4'd8
  } region_e;

endpackage

// File: rtl/dsr_decode.sv
module dsr_decode
  import dsr_pkg::*;
#(
  parameter int          AW       = 16,
  parameter int unsigned XRAM_LO  = 'h0000,
  parameter int unsigned XRAM_HI  = 'h1FFF,
  parameter int unsigned CREG_LO  = 'h3000,
  parameter int unsigned CREG_HI  = 'h3EFF,
  parameter int unsigned STAT_AD  = 'h3F00,
  parameter int unsigned HOLD_AD  = 'h3F01,
  parameter int unsigned SFRX_LO  = 'h3F80,
  parameter int unsigned SFRX_HI  = 'h3FFF,
  parameter int unsigned RBLK_LO  = 'h4000,
  parameter int unsigned RBLK_HI  = 'h4FFF,
  parameter int unsigned RNB_LO   = 'h5000,
  parameter int unsigned RNB_HI   = 'h5FFF
) (
  input  logic [1:0]    kind,
  input  logic [AW-1:0] addr,
  output region_e       region,
  output logic [AW-1:0] tgt_addr
);

  localparam int IW = 8;

  function automatic logic in_win(input logic [AW-1:0] a,
                                  input logic [AW-1:0] lo,
                                  input logic [AW-1:0] hi);
    return (a >= lo) && (a <= hi);
  endfunction

  logic [AW-1:0] low_addr;
  assign low_addr = {{(AW-IW){1'b0}}, addr[IW-1:0]};

  always_comb begin
    region   = RG_NONE;
    tgt_addr = addr;
    if (kind != KIND_EXT) begin
      tgt_addr = low_addr;
      if (addr[IW-1] && (kind == KIND_DIR)) region = RG_SFR;
      else                                  region = RG_IRAM;
    end else if (in_win(addr, AW'(XRAM_LO), AW'(XRAM_HI))) begin
      region = RG_XRAM;
    end else if (in_win(addr, AW'(CREG_LO), AW'(CREG_HI))) begin
      region = RG_CREG;
    end else if (addr == AW'(STAT_AD)) begin
      region = RG_STAT;
    end else if (addr == AW'(HOLD_AD)) begin
      region = RG_HOLD;
    end else if (in_win(addr, AW'(SFRX_LO), AW'(SFRX_HI))) begin
      region   = RG_SFR;
      tgt_addr = low_addr;
    end else if (in_win(addr, AW'(RBLK_LO), AW'(RBLK_HI))) begin
      region = RG_RBLK;
    end else if (in_win(addr, AW'(RNB_LO), AW'(RNB_HI))) begin
      region = RG_RNB;
    end
  end

endmodule

// File: rtl/dsr_radio_eng.sv
module dsr_radio_eng #(
  parameter int DW  = 8,
  parameter int RAW = 12
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           launch,
  input  logic           launch_nb,
  input  logic           launch_we,
  input  logic [RAW-1:0] launch_addr,
  input  logic [DW-1:0]  launch_wdata,
  input  logic           rad_ack,
  input  logic [DW-1:0]  rad_rdata,
  output logic           busy,
  output logic           blk_done,
  output logic [DW-1:0]  hold,
  output logic           rad_req,
  output logic [RAW-1:0] rad_addr,
  output logic           rad_we,
  output logic [DW-1:0]  rad_wdata
);

  logic           busy_q, busy_d;
  logic           nb_q, we_q;
  logic [RAW-1:0] addr_q;
  logic [DW-1:0]  wdata_q, hold_q;
  logic           cap_en, hold_en;

  // next state and enables
  always_comb begin
    busy_d  = busy_q;
    cap_en  = 1'b0;
    hold_en = 1'b0;
    if (busy_q) begin
      if (rad_ack) begin
        busy_d  = 1'b0;
        hold_en = nb_q && !we_q;
      end
    end else if (launch) begin
      busy_d = 1'b1;
      cap_en = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      nb_q    <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      hold_q  <= '0;
    end else begin
      busy_q <= busy_d;
      if (cap_en) begin
        nb_q    <= launch_nb;
        we_q    <= launch_we;
        addr_q  <= launch_addr;
        wdata_q <= launch_wdata;
      end
      if (hold_en) hold_q <= rad_rdata;
    end
  end

  assign busy      = busy_q;
  assign blk_done  = busy_q && !nb_q && rad_ack;
  assign hold      = hold_q;
  assign rad_req   = busy_q;
  assign rad_addr  = addr_q;
  assign rad_we    = we_q;
  assign rad_wdata = wdata_q;

  AST_RAD_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (rad_req && !rad_ack) |=> (rad_req && $stable(rad_addr) && $stable(rad_we) && $stable(rad_wdata))); // R6
  AST_HOLD_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (rad_req && rad_ack && !rad_we && nb_q) |=> (hold == $past(rad_rdata))); // R9
  AST_ACK_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    (rad_req && rad_ack) |=> !rad_req); // R7

endmodule

// File: rtl/dsr_router.sv
module dsr_router
  import dsr_pkg::*;
#(
  parameter int AW  = 16,
  parameter int DW  = 8,
  parameter int RAW = 12
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cpu_req,
  input  logic [1:0]               cpu_kind,
  input  logic [AW-1:0]            cpu_addr,
  input  logic                     cpu_we,
  input  logic [DW-1:0]            cpu_wdata,
  output logic [DW-1:0]            cpu_rdata,
  output logic                     cpu_ready,
  output logic [NUM_SHARED-1:0]    tgt_req,
  output logic [AW-1:0]            tgt_addr,
  output logic                     tgt_we,
  output logic [DW-1:0]            tgt_wdata,
  input  logic [NUM_SHARED*DW-1:0] tgt_rdata,
  input  logic [NUM_SHARED-1:0]    tgt_ack,
  output logic                     rad_req,
  output logic [RAW-1:0]           rad_addr,
  output logic                     rad_we,
  output logic [DW-1:0]            rad_wdata,
  input  logic [DW-1:0]            rad_rdata,
  input  logic                     rad_ack
);

  localparam int SW = $clog2(NUM_SHARED);

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  region_e       region;
  logic [3:0]    region_bits;
  logic [AW-1:0] dec_addr;

  dsr_decode #(.AW(AW)) u_decode (
    .kind     (cpu_kind),
    .addr     (cpu_addr),
    .region   (region),
    .tgt_addr (dec_addr)
  );
  assign region_bits = region;

  logic          radio_hit, launch;
  logic          eng_busy, blk_done;
  logic [DW-1:0] hold;

  assign radio_hit = cpu_req && ((region == RG_RBLK) || (region == RG_RNB));
  assign launch    = radio_hit && !eng_busy;

  dsr_radio_eng #(.DW(DW), .RAW(RAW)) u_radio (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .launch       (launch),
    .launch_nb    (region == RG_RNB),
    .launch_we    (cpu_we),
    .launch_addr  (cpu_addr[RAW-1:0]),
    .launch_wdata (cpu_wdata),
    .rad_ack      (rad_ack),
    .rad_rdata    (rad_rdata),
    .busy         (eng_busy),
    .blk_done     (blk_done),
    .hold         (hold),
    .rad_req      (rad_req),
    .rad_addr     (rad_addr),
    .rad_we       (rad_we),
    .rad_wdata    (rad_wdata)
  );

  // shared fast-target bus
  logic [DW-1:0] sh_rdata [NUM_SHARED];
  for (genvar g = 0; g < NUM_SHARED; g++) begin : g_tgt
    assign tgt_req[g]  = cpu_req && (region_bits == 4'(g));
    assign sh_rdata[g] = tgt_rdata[g*DW +: DW];
  end
  assign tgt_addr  = dec_addr;
  assign tgt_we    = cpu_we && (|tgt_req);
  assign tgt_wdata = cpu_wdata;

  // completion and read-data return
  always_comb begin
    cpu_ready = 1'b0;
    cpu_rdata = '0;
    if (cpu_req) begin
      unique case (region)
        RG_IRAM, RG_SFR, RG_XRAM, RG_CREG: begin
          cpu_ready = tgt_ack[region_bits[SW-1:0]];
          cpu_rdata = sh_rdata[region_bits[SW-1:0]];
        end
        RG_RBLK: begin
          cpu_ready = blk_done;
          cpu_rdata = rad_rdata;
        end
        RG_RNB:  cpu_ready = !eng_busy;
        RG_STAT: begin
          cpu_ready = 1'b1;
          cpu_rdata = {{(DW-1){1'b0}}, eng_busy};
        end
        RG_HOLD: begin
          cpu_ready = 1'b1;
          cpu_rdata = hold;
        end
        default: cpu_ready = 1'b1;
      endcase
    end
  end

  AST_LOW_IRAM: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cpu_req && (cpu_kind != KIND_EXT) && !cpu_addr[7]) |-> (tgt_req == NUM_SHARED'(1))); // R1
  AST_HIGH_DIR_SFR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cpu_req && (cpu_kind == KIND_DIR) && cpu_addr[7]) |-> (tgt_req == NUM_SHARED'(2))); // R2
  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $onehot0(tgt_req)); // R4
  AST_BLK_ON_ACK: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cpu_req && (region == RG_RBLK) && cpu_ready) |-> rad_ack); // R5
  AST_NB_STARTS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cpu_req && (region == RG_RNB) && cpu_ready) |=> rad_req); // R6
  AST_STALL_BUSY: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cpu_req && (region == RG_RNB) && rad_req) |-> !cpu_ready); // R7
  AST_NONE_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cpu_req && (region == RG_NONE)) |-> (cpu_ready && (cpu_rdata == '0) && (tgt_req == '0))); // R10

endmodule

// File: tb/dsr_router_tb_top.sv
module dsr_router_tb_top;

  localparam int AW = 16, DW = 8, RAW = 12, NT = 4, RLAT = 3;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic              rst_n;
  logic              cpu_req, cpu_we, cpu_ready;
  logic [1:0]        cpu_kind;
  logic [AW-1:0]     cpu_addr, tgt_addr;
  logic [DW-1:0]     cpu_wdata, cpu_rdata, tgt_wdata, rad_wdata, rad_rdata;
  logic [NT-1:0]     tgt_req, tgt_ack;
  logic              tgt_we, rad_req, rad_we, rad_ack;
  logic [NT*DW-1:0]  tgt_rdata;
  logic [RAW-1:0]    rad_addr;

  dsr_router dut_i (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_kind(cpu_kind), .cpu_addr(cpu_addr), .cpu_we(cpu_we),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready),
    .tgt_req(tgt_req), .tgt_addr(tgt_addr), .tgt_we(tgt_we), .tgt_wdata(tgt_wdata),
    .tgt_rdata(tgt_rdata), .tgt_ack(tgt_ack),
    .rad_req(rad_req), .rad_addr(rad_addr), .rad_we(rad_we), .rad_wdata(rad_wdata),
    .rad_rdata(rad_rdata), .rad_ack(rad_ack)
  );

  // fast targets answer at once; data is the low address byte xor a per-target salt
  assign tgt_ack = tgt_req;
  always_comb begin
    for (int i = 0; i < NT; i++) tgt_rdata[i*DW +: DW] = tgt_addr[7:0] ^ 8'((i + 1) * 17);
  end

  // radio target: acknowledges in its RLAT-th request cycle
  logic [3:0] rcnt_t;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) rcnt_t <= 4'd0;
    else        rcnt_t <= (rad_req && !rad_ack) ? rcnt_t + 4'd1 : 4'd0;
  end
  assign rad_ack   = rad_req && (rcnt_t == 4'(RLAT - 1));
  assign rad_rdata = rad_addr[7:0] ^ 8'h5A;

  int checks = 0, errors = 0;
  bit armed = 0, finished = 0;

  // reference model state
  int          mbusy = 0, mcnt = 0, mnb = 0, mwe = 0;
  logic [11:0] maddr = '0;
  logic [7:0]  mwd = '0, mhold = '0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // rg: 0 iram 1 sfr 2 xram 3 creg 4 radio-blocking 5 radio-nb 6 status 7 hold 8 unmapped
  task automatic decode_ref(input logic [1:0] k, input logic [15:0] a,
                            output int rg, output string tag, output logic [15:0] ta);
    ta = a;
    if (k != 2'd2) begin
      ta = {8'h00, a[7:0]};
      if (!a[7])          begin rg = 0; tag = "R1"; end
      else if (k == 2'd0) begin rg = 1; tag = "R2"; end
      else                begin rg = 0; tag = "R3"; end
    end else if (a <= 16'h1FFF)                  begin rg = 2; tag = "R4"; end
    else if (a >= 16'h3000 && a <= 16'h3EFF)     begin rg = 3; tag = "R4"; end
    else if (a == 16'h3F00)                      begin rg = 6; tag = "R8"; end
    else if (a == 16'h3F01)                      begin rg = 7; tag = "R9"; end
    else if (a >= 16'h3F80 && a <= 16'h3FFF)     begin rg = 1; tag = "R4"; ta = {8'h00, a[7:0]}; end
    else if (a >= 16'h4000 && a <= 16'h4FFF)     begin rg = 4; tag = "R5"; end
    else if (a >= 16'h5000 && a <= 16'h5FFF)     begin rg = 5; tag = "R6"; end
    else                                         begin rg = 8; tag = "R10"; end
  endtask

  task automatic compare_cycle();
    int rg; string tag; logic [15:0] ta;
    bit e_ready; logic [7:0] e_rdata; logic [3:0] e_treq; bit m_ack;
    decode_ref(cpu_kind, cpu_addr, rg, tag, ta);
    m_ack = (mbusy != 0) && (mcnt == RLAT - 1);
    e_ready = 0; e_rdata = 8'h00; e_treq = 4'h0;
    if (cpu_req) begin
      if ((rg == 4 || rg == 5) && mbusy != 0 && (rg == 5 || mnb != 0)) tag = "R7";
      case (rg)
        0, 1, 2, 3: begin
          e_treq = 4'(1 << rg); e_ready = 1; e_rdata = ta[7:0] ^ 8'((rg + 1) * 17);
        end
        4: begin e_ready = (mbusy != 0) && (mnb == 0) && m_ack; e_rdata = maddr[7:0] ^ 8'h5A; end
        5: e_ready = (mbusy == 0);
        6: begin e_ready = 1; e_rdata = {7'h0, mbusy != 0}; end
        7: begin e_ready = 1; e_rdata = mhold; end
        default: e_ready = 1;
      endcase
    end
    chk(cpu_ready === e_ready, tag, "cpu_ready", 32'(cpu_ready), 32'(e_ready));
    if (e_ready && !cpu_we) chk(cpu_rdata === e_rdata, tag, "cpu_rdata", 32'(cpu_rdata), 32'(e_rdata));
    chk(tgt_req === e_treq, tag, "tgt_req", 32'(tgt_req), 32'(e_treq));
    if (e_treq != 0) begin
      chk(tgt_addr === ta, tag, "tgt_addr", 32'(tgt_addr), 32'(ta));
      chk(tgt_we === cpu_we, tag, "tgt_we", 32'(tgt_we), 32'(cpu_we));
      if (cpu_we) chk(tgt_wdata === cpu_wdata, tag, "tgt_wdata", 32'(tgt_wdata), 32'(cpu_wdata));
    end
    chk(rad_req === (mbusy != 0), (mnb != 0) ? "R6" : "R5", "rad_req", 32'(rad_req), 32'(mbusy));
    if (mbusy != 0) begin
      chk(rad_addr === maddr, (mnb != 0) ? "R6" : "R5", "rad_addr", 32'(rad_addr), 32'(maddr));
      chk(rad_we === (mwe != 0), (mnb != 0) ? "R6" : "R5", "rad_we", 32'(rad_we), 32'(mwe));
      if (mwe != 0) chk(rad_wdata === mwd, "R6", "rad_wdata", 32'(rad_wdata), 32'(mwd));
    end
  endtask

  always begin
    @(negedge clk); #5;
    if (armed && !finished) compare_cycle();
  end

  // model update on each edge
  always @(posedge clk) begin
    if (armed) begin
      int rg; string tag; logic [15:0] ta;
      decode_ref(cpu_kind, cpu_addr, rg, tag, ta);
      if (mbusy != 0) begin
        if (mcnt == RLAT - 1) begin
          mbusy = 0; mcnt = 0;
          if (mnb != 0 && mwe == 0) mhold = maddr[7:0] ^ 8'h5A;
        end else mcnt++;
      end else if (cpu_req && (rg == 4 || rg == 5)) begin
        mbusy = 1; mcnt = 0; mnb = (rg == 5); mwe = cpu_we;
        maddr = cpu_addr[11:0]; mwd = cpu_wdata;
      end
    end
  end

  task automatic acc(input logic [1:0] k, input logic [15:0] a, input bit we, input logic [7:0] wd);
    @(negedge clk);
    cpu_req = 1; cpu_kind = k; cpu_addr = a; cpu_we = we; cpu_wdata = wd;
    forever begin
      #6;
      if (cpu_ready) begin @(posedge clk); break; end
      @(negedge clk);
    end
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    cpu_req = 0; cpu_we = 0;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    rst_n = 0; cpu_req = 0; cpu_kind = 2'd0; cpu_addr = '0; cpu_we = 0; cpu_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    #5;
    // R11: idle after reset
    chk(tgt_req === 4'h0, "R11", "tgt_req", 32'(tgt_req), 0);
    chk(rad_req === 1'b0, "R11", "rad_req", 32'(rad_req), 0);
    chk(cpu_ready === 1'b0, "R11", "cpu_ready", 32'(cpu_ready), 0);
    armed = 1;
    acc(2, 16'h3F01, 0, 0);          // R11 holding byte is zero, R9 read path
    acc(2, 16'h3F00, 0, 0);          // R8 idle status
    // R1
    acc(0, 16'h0005, 0, 0); acc(1, 16'h007F, 1, 8'hA1); acc(3, 16'h0040, 0, 0);
    // R2
    acc(0, 16'h0080, 0, 0); acc(0, 16'h00FF, 0, 0); acc(0, 16'h0090, 1, 8'h3C);
    // R3
    acc(1, 16'h0080, 0, 0); acc(3, 16'h00FF, 1, 8'h77); acc(1, 16'h00C3, 0, 0);
    // R4
    acc(2, 16'h0000, 0, 0); acc(2, 16'h1FFF, 1, 8'h12); acc(2, 16'h3000, 0, 0);
    acc(2, 16'h3EFF, 0, 0); acc(2, 16'h3F80, 0, 0); acc(2, 16'h3FFF, 1, 8'hEE);
    // R10
    acc(2, 16'h2000, 1, 8'h99); acc(2, 16'h3F02, 0, 0); acc(2, 16'h3F7F, 0, 0);
    acc(2, 16'h6000, 0, 0); acc(2, 16'hFFFF, 1, 8'h01);
    // R5
    acc(2, 16'h4012, 0, 0); acc(2, 16'h4FFF, 1, 8'hC5); idle(2);
    // R6, R8, R9: nb read, then status and holding reads across the ack cycle
    acc(2, 16'h5034, 0, 0);
    acc(2, 16'h3F00, 0, 0); acc(2, 16'h3F01, 0, 0); acc(2, 16'h3F00, 0, 0);
    acc(2, 16'h3F01, 0, 0); acc(2, 16'h3F01, 0, 0);
    // R7: nb write then nb read back to back, then blocking right after nb
    acc(2, 16'h5001, 1, 8'h6B); acc(2, 16'h5002, 0, 0);
    acc(2, 16'h4003, 0, 0); acc(2, 16'h3F01, 0, 0);
    // nb pending while fast targets are used
    acc(2, 16'h5FFF, 0, 0); acc(0, 16'h0011, 0, 0); acc(0, 16'h0091, 0, 0);
    acc(2, 16'h3F00, 0, 0); acc(2, 16'h1000, 1, 8'h5E); acc(2, 16'h3F01, 0, 0);
    idle(4);
    acc(2, 16'h3F01, 0, 0); acc(2, 16'h3F00, 0, 0);
    idle(3);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired at %0t", $time);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule